// File: doc/BRIEF.md
# Programmable Sum-of-Products Macrocell Array

The block is the logic core of a small programmable device. There are eight output cells. Each cell forms a sum of eight product terms. Each term is an AND of chosen literals from a shared signal vector, which holds the sampled input pins, the power-down pin column and the cell register feedback. A cell drives its pin either straight from the sum (combinational) or from a register loaded with the sum at each clock edge (registered). The pin polarity is inverted in both cases. Each cell has a ninth product term that serves as its output enable. In registered mode the cell can take its enable from a shared active-low enable pin instead.

Pins are sampled into an input stage at every clock edge. Because of this, a combinational output follows its inputs one cycle after they are applied. A power-down option, once enabled, freezes all sampling and state while the power-down pin is high. A preload command forces any subset of registers to chosen values. A one-way lock bit blocks verify reads, preload and all further writes, while the 64-bit signature stays readable.

The configuration port accepts one command per cycle: `cfg_en`, a 3-bit opcode, an address and a data word.

Top module: `plm_array`

## Requirements
- R1: A combinational cell (mode bit 0) drives its pin with the inverse of the OR of its eight sum terms, which are rows cell*9+0..7. The terms are evaluated on the pins sampled at the previous clock edge.
- R2: Row bit k requires literal k to be 1, and row bit 17+k requires it to be 0. The literal vector is: bits 0..7 for the input pins, bit 8 for the power-down column, bits 9..16 for the registers of cells 0..7. A row with no bits set is true. A row that requires both polarities of one literal is false.
- R3: A registered cell (mode bit 1) loads its sum at each edge and drives its pin with the inverse of the register.
- R4: While reset is low, all registers are 0 and every cell is registered with no enable-pin selection. All pins therefore read 1 and are enabled. All rows, the signature, the lock bit, the error flag and the read outputs are cleared.
- R5: The output enable is row cell*9+8. The exception is a registered cell whose enable-select bit is 1: it is enabled when the sampled `oe_n` is 0. A combinational cell ignores the enable-select bit.
- R6: With power-down enabled (opcode 2, data bit 0) and `pd_pin` high at an edge, nothing is sampled or loaded at that edge: no pins, no commands, no register updates. All output values and enables hold.
- R7: The first edge with `pd_pin` low samples inputs and commands again, and the registers resume from the values held before power-down.
- R8: With power-down disabled, the sampled `pd_pin` is array literal 8. With power-down enabled, that literal reads 0.
- R9: Preload (opcode 5) loads register i with data bit i wherever mask bit 8+i is 1. No register clocks in a preload cycle.
- R10: The lock (opcode 4) takes effect at the next edge. From then on, a verify read (opcode 6) returns 0 with `cfg_rdok` low. Preload is refused. A signature read (opcode 7, address bit 0 selects the upper half) still returns data with `cfg_rdok` high.
- R11: Once locked, any opcode 0..5 has no effect and sets `cfg_err`, which stays set until reset.
- R12: A verify read of row a < 72 presents that row on `cfg_rdata` with `cfg_rdok` high one cycle later. Opcode 0 writes a row, and opcode 1 writes a cell's mode (bit 0) and enable select (bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| in_pins | input | 8 | Dedicated logic inputs |
| pd_pin | input | 1 | Power-down pin or array input |
| oe_n | input | 1 | Shared active-low output enable |
| cfg_en | input | 1 | Configuration command valid |
| cfg_op | input | 3 | Command opcode |
| cfg_addr | input | 7 | Row, cell or signature-half address |
| cfg_wdata | input | 34 | Command data |
| out_val | output | 8 | Cell pin values |
| out_oe | output | 8 | Cell pin drive enables |
| cfg_rdata | output | 34 | Read data |
| cfg_rdok | output | 1 | Read data valid |
| cfg_err | output | 1 | Sticky locked-write error |

## Verification
A corrupted row, register or input sample shows up at `out_val` on the very next sampled cycle. It shows directly for a combinational cell, and for a registered cell it shows one edge later through the sum and feedback. Any state that slips during power-down appears as a changed pin or enable at the first compare after the faulty edge. A leaked write or a missing lock shows at the next read or as a missing `cfg_err`. For this reason, a reference model steps beside the design and compares every port at every cycle.

// File: rtl/plm_array.sv
module plm_array #(
  parameter int NI   = 8,
  parameter int NO   = 8,
  parameter int TPC  = 8,
  parameter int SIGW = 64,
  localparam int NSIG  = NI + 1 + NO,
  localparam int RW    = 2 * NSIG,
  localparam int TROWS = TPC + 1,
  localparam int NROWS = NO * TROWS,
  localparam int AW    = $clog2(NROWS),
  localparam int CW    = $clog2(NO),
  localparam int HW    = SIGW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NI-1:0] in_pins,
  input  logic          pd_pin,
  input  logic          oe_n,
  input  logic          cfg_en,
  input  logic [2:0]    cfg_op,
  input  logic [AW-1:0] cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  output logic [NO-1:0] out_val,
  output logic [NO-1:0] out_oe,
  output logic [RW-1:0] cfg_rdata,
  output logic          cfg_rdok,
  output logic          cfg_err
);
  localparam logic [2:0] OP_ROW = 3'd0, OP_CELL = 3'd1, OP_GLB = 3'd2, OP_SIG = 3'd3;
  localparam logic [2:0] OP_LOCK = 3'd4, OP_PRE = 3'd5, OP_RDROW = 3'd6, OP_RDSIG = 3'd7;

  logic [RW-1:0]   rows [NROWS];
  logic [NO-1:0]   reg_q, mode_q, oes_q;
  logic [NI-1:0]   in_q;
  logic            pdp_q, oen_q, pden_q, sec_q;
  logic [SIGW-1:0] sig_q;
  logic [NROWS-1:0] term;
  logic [NO-1:0]   sum_v, pt_oe;
  logic [NSIG-1:0] lits;

  wire pd_act = pden_q & pd_pin;
  wire take   = cfg_en & ~pd_act;
  wire wr_op  = (cfg_op <= OP_PRE);
  wire wr_ok  = take & wr_op & ~sec_q;
  wire [NO-1:0] pval  = cfg_wdata[NO-1:0];
  wire [NO-1:0] pmask = cfg_wdata[2*NO-1:NO];

  assign lits = {reg_q, pdp_q & ~pden_q, in_q};

  genvar r, c;
  generate
    for (r = 0; r < NROWS; r++) begin : g_term
      assign term[r] = &((~rows[r][NSIG-1:0] | lits) & (~rows[r][RW-1:NSIG] | ~lits));
    end
    for (c = 0; c < NO; c++) begin : g_cell
      assign sum_v[c]   = |term[c*TROWS +: TPC];
      assign pt_oe[c]   = term[c*TROWS + TPC];
      assign out_val[c] = mode_q[c] ? ~reg_q[c] : ~sum_v[c];
      assign out_oe[c]  = (mode_q[c] & oes_q[c]) ? ~oen_q : pt_oe[c];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NROWS; i++) rows[i] <= '0;
    end else if (wr_ok && cfg_op == OP_ROW && cfg_addr < AW'(NROWS)) begin
      rows[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q     <= '0;
      mode_q    <= '1;
      oes_q     <= '0;
      in_q      <= '0;
      pdp_q     <= 1'b0;
      oen_q     <= 1'b1;
      pden_q    <= 1'b0;
      sec_q     <= 1'b0;
      sig_q     <= '0;
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
      cfg_rdok  <= 1'b0;
    end else if (!pd_act) begin
      in_q  <= in_pins;
      pdp_q <= pd_pin;
      oen_q <= oe_n;
      if (take && cfg_op == OP_PRE) begin
        if (!sec_q) reg_q <= (reg_q & ~pmask) | (pval & pmask);
      end else begin
        reg_q <= sum_v;
      end
      cfg_rdok <= 1'b0;
      if (take && wr_op && sec_q) cfg_err <= 1'b1;
      if (take && cfg_op == OP_RDROW) begin
        cfg_rdok  <= ~sec_q;
        cfg_rdata <= (sec_q || cfg_addr >= AW'(NROWS)) ? '0 : rows[cfg_addr];
      end
      if (take && cfg_op == OP_RDSIG) begin
        cfg_rdok  <= 1'b1;
        cfg_rdata <= RW'(cfg_addr[0] ? sig_q[SIGW-1:HW] : sig_q[HW-1:0]);
      end
      if (wr_ok) begin
        case (cfg_op)
          OP_CELL: if (cfg_addr < AW'(NO)) begin
            mode_q[cfg_addr[CW-1:0]] <= cfg_wdata[0];
            oes_q[cfg_addr[CW-1:0]]  <= cfg_wdata[1];
          end
          OP_GLB:  pden_q <= cfg_wdata[0];
          OP_SIG:  if (cfg_addr[0]) sig_q[SIGW-1:HW] <= cfg_wdata[HW-1:0];
                   else sig_q[HW-1:0] <= cfg_wdata[HW-1:0];
          OP_LOCK: sec_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_PD_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    pd_act |=> $stable(reg_q)); // R6
  AST_PD_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pd_act |=> ($stable(out_val) && $stable(out_oe))); // R6
  AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q |=> sec_q); // R10
  AST_LOCKED_NO_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_op == OP_RDROW && sec_q) |=> (!cfg_rdok && cfg_rdata == '0)); // R10
  AST_LOCKED_NO_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cfg_op == OP_PRE && sec_q) |=> $stable(reg_q)); // R10
  AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wr_op && sec_q) |=> cfg_err); // R11
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R11
endmodule

// File: tb/sim_plm_array.sv
module sim_plm_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_pins = '0;
  logic pd_pin = 1'b0, oe_n = 1'b0, cfg_en = 1'b0;
  logic [2:0] cfg_op = '0;
  logic [6:0] cfg_addr = '0;
  logic [33:0] cfg_wdata = '0;
  logic [7:0] out_val, out_oe;
  logic [33:0] cfg_rdata;
  logic cfg_rdok, cfg_err;

  plm_array u0 (.clk(clk), .rst_n(rst_n), .in_pins(in_pins), .pd_pin(pd_pin), .oe_n(oe_n),
    .cfg_en(cfg_en), .cfg_op(cfg_op), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_val(out_val), .out_oe(out_oe), .cfg_rdata(cfg_rdata), .cfg_rdok(cfg_rdok), .cfg_err(cfg_err));

  always #5 clk = ~clk;

  int vecs = 0, fails = 0;
  string cur = "R4";
  localparam logic [33:0] FALSE_ROW = 34'h1 | (34'h1 << 17);

  logic [33:0] m_row [72];
  logic [7:0] m_in, m_reg, m_mode, m_oes, e_sum, e_val, e_oe;
  logic m_pdp, m_oen, m_pden, m_sec, m_err, m_rdok;
  logic [33:0] m_rdata;
  logic [63:0] m_sig;

  task automatic eval();
    logic [16:0] s;
    logic [33:0] rw;
    logic [8:0] tm;
    s = {m_reg, m_pdp & ~m_pden, m_in};
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 9; t++) begin
        rw = m_row[c*9+t];
        tm[t] = 1'b1;
        for (int k = 0; k < 17; k++) begin
          if (rw[k] && !s[k]) tm[t] = 1'b0;
          if (rw[17+k] && s[k]) tm[t] = 1'b0;
        end
      end
      e_sum[c] = |tm[7:0];
      e_val[c] = m_mode[c] ? ~m_reg[c] : ~e_sum[c];
      e_oe[c]  = (m_mode[c] && m_oes[c]) ? ~m_oen : tm[8];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 72; i++) m_row[i] = '0;
      m_in = 0; m_reg = 0; m_mode = 8'hFF; m_oes = 0; m_pdp = 0; m_oen = 1;
      m_pden = 0; m_sec = 0; m_err = 0; m_rdok = 0; m_rdata = 0; m_sig = 0;
    end else if (!(m_pden && pd_pin)) begin
      eval();
      if (cfg_en && cfg_op == 3'd5) begin
        if (!m_sec) for (int i = 0; i < 8; i++) if (cfg_wdata[8+i]) m_reg[i] = cfg_wdata[i];
      end else m_reg = e_sum;
      m_rdok = 0;
      if (cfg_en) begin
        if (cfg_op <= 3'd5 && m_sec) m_err = 1;
        else case (cfg_op)
          3'd0: if (cfg_addr < 72) m_row[cfg_addr] = cfg_wdata;
          3'd1: if (cfg_addr < 8) begin m_mode[cfg_addr[2:0]] = cfg_wdata[0]; m_oes[cfg_addr[2:0]] = cfg_wdata[1]; end
          3'd2: m_pden = cfg_wdata[0];
          3'd3: if (cfg_addr[0]) m_sig[63:32] = cfg_wdata[31:0]; else m_sig[31:0] = cfg_wdata[31:0];
          3'd4: m_sec = 1;
          3'd6: begin m_rdok = !m_sec; m_rdata = (m_sec || cfg_addr >= 72) ? 34'h0 : m_row[cfg_addr]; end
          3'd7: begin m_rdok = 1; m_rdata = {2'b00, cfg_addr[0] ? m_sig[63:32] : m_sig[31:0]}; end
          default: ;
        endcase
      end
      m_in = in_pins; m_pdp = pd_pin; m_oen = oe_n;
    end
  end

  task automatic compare();
    eval();
    vecs++;
    if (out_val !== e_val || out_oe !== e_oe || cfg_rdata !== m_rdata || cfg_rdok !== m_rdok || cfg_err !== m_err) begin
      fails++;
      $display("FAIL %s: val %h/%h oe %h/%h rdata %h/%h rdok %b/%b err %b/%b (actual/expected)",
        cur, out_val, e_val, out_oe, e_oe, cfg_rdata, m_rdata, cfg_rdok, m_rdok, cfg_err, m_err);
    end
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cfg(logic [2:0] op, logic [6:0] a, logic [33:0] d);
    cfg_en = 1; cfg_op = op; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_en = 0;
  endtask

  function automatic logic [33:0] rnd_row();
    logic [63:0] a, b, c;
    a = {$urandom(), $urandom()}; b = {$urandom(), $urandom()}; c = {$urandom(), $urandom()};
    return 34'(a & b & c);
  endfunction

  logic [7:0] prev_v, prev_oe;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare();
    chk("R4 pins", 64'(out_val), 64'hFF);
    chk("R4 enables", 64'(out_oe), 64'hFF);
    rst_n = 1;

    cur = "R1";
    cfg(3'd0, 7'd0, 34'h1 | (34'h1 << 18));
    for (int t = 1; t < 8; t++) cfg(3'd0, 7'(t), FALSE_ROW);
    cfg(3'd1, 7'd0, 34'h0);
    in_pins = 8'h01; tick();
    chk("R1 term hit", 64'(out_val[0]), 64'h0);
    cur = "R2";
    in_pins = 8'h03; tick();
    chk("R2 complement literal", 64'(out_val[0]), 64'h1);

    cur = "R3";
    in_pins = 8'h00; cfg(3'd1, 7'd0, 34'h1);
    in_pins = 8'h03; tick();
    in_pins = 8'h01; tick();
    chk("R3 reg from older sample", 64'(out_val[0]), 64'h1);
    tick();
    chk("R3 reg loaded", 64'(out_val[0]), 64'h0);

    cur = "R5";
    oe_n = 1; cfg(3'd1, 7'd0, 34'h3);
    chk("R5 pin disable", 64'(out_oe[0]), 64'h0);
    oe_n = 0; tick();
    chk("R5 pin enable", 64'(out_oe[0]), 64'h1);
    oe_n = 1; cfg(3'd1, 7'd0, 34'h2);
    chk("R5 comb ignores select", 64'(out_oe[0]), 64'h1);

    cur = "R8";
    cfg(3'd0, 7'd9, 34'h100);
    for (int t = 10; t < 17; t++) cfg(3'd0, 7'(t), FALSE_ROW);
    cfg(3'd1, 7'd1, 34'h0);
    pd_pin = 1; tick();
    chk("R8 pd column high", 64'(out_val[1]), 64'h0);
    pd_pin = 0; tick();
    chk("R8 pd column low", 64'(out_val[1]), 64'h1);

    cur = "R12";
    cfg(3'd0, 7'd70, 34'h2_5A5A_1234);
    cfg(3'd6, 7'd70, 34'h0);
    chk("R12 verify data", 64'(cfg_rdata), 64'h2_5A5A_1234);
    chk("R12 verify valid", 64'(cfg_rdok), 64'h1);

    cur = "R1 R2 R3 R5 R8 random";
    for (int i = 0; i < 72; i++) cfg(3'd0, 7'(i), rnd_row());
    for (int i = 0; i < 8; i++) cfg(3'd1, 7'(i), 34'($urandom % 4));
    for (int i = 0; i < 400; i++) begin
      in_pins = 8'($urandom); pd_pin = 1'($urandom); oe_n = 1'($urandom);
      tick();
    end
    pd_pin = 0;

    cur = "R9";
    for (int i = 0; i < 8; i++) cfg(3'd1, 7'(i), 34'h1);
    prev_v = out_val;
    cfg(3'd5, 7'd0, 34'h0FA5);
    chk("R9 masked load", 64'(out_val[3:0]), 64'hA);
    chk("R9 unmasked hold", 64'(out_val[7:4]), 64'(prev_v[7:4]));

    cur = "R6";
    cfg(3'd0, 7'd70, 34'h1_2345_6789);
    cfg(3'd2, 7'd0, 34'h1);
    cfg(3'd5, 7'd0, 34'hFF3C);
    prev_oe = out_oe;
    pd_pin = 1;
    for (int i = 0; i < 5; i++) begin
      in_pins = 8'($urandom); oe_n = 1'($urandom);
      cfg_en = 1; cfg_op = 3'd0; cfg_addr = 7'd70; cfg_wdata = rnd_row();
      tick();
      chk("R6 values held", 64'(out_val), 64'hC3);
      chk("R6 enables held", 64'(out_oe), 64'(prev_oe));
    end
    cfg_en = 0;
    cur = "R7";
    pd_pin = 0;
    cfg(3'd5, 7'd0, 34'h0);
    chk("R7 state carried over", 64'(out_val), 64'hC3);
    cfg(3'd6, 7'd70, 34'h0);
    chk("R6 write during power-down ignored", 64'(cfg_rdata), 64'h1_2345_6789);

    cur = "R6 R7 random";
    for (int i = 0; i < 300; i++) begin
      pd_pin = ($urandom % 3) == 0;
      in_pins = 8'($urandom); oe_n = 1'($urandom);
      cfg_en = pd_pin; cfg_op = 3'($urandom); cfg_addr = 7'($urandom % 72); cfg_wdata = rnd_row();
      tick();
    end
    cfg_en = 0; pd_pin = 0;

    cur = "R10";
    cfg(3'd3, 7'd0, 34'hCAFE_0123);
    cfg(3'd3, 7'd1, 34'h89AB_4567);
    cfg(3'd4, 7'd0, 34'h0);
    cfg(3'd6, 7'd70, 34'h0);
    chk("R10 verify refused data", 64'(cfg_rdata), 64'h0);
    chk("R10 verify refused valid", 64'(cfg_rdok), 64'h0);
    cfg(3'd7, 7'd1, 34'h0);
    chk("R10 signature readable", 64'(cfg_rdata), 64'h89AB_4567);
    chk("R10 signature valid", 64'(cfg_rdok), 64'h1);
    chk("R11 no error before locked write", 64'(cfg_err), 64'h0);
    prev_v = out_val;
    cfg(3'd5, 7'd0, 34'hFF00);
    chk("R10 preload refused", 64'(out_val), 64'(prev_v));
    cur = "R11";
    chk("R11 error raised", 64'(cfg_err), 64'h1);
    cfg(3'd2, 7'd0, 34'h0);
    prev_v = out_val;
    pd_pin = 1; in_pins = ~in_pins; tick();
    chk("R11 locked write ignored", 64'(out_val), 64'(prev_v));
    pd_pin = 0;

    cur = "R10 R11 random";
    for (int i = 0; i < 100; i++) begin
      in_pins = 8'($urandom); pd_pin = ($urandom % 4) == 0; oe_n = 1'($urandom);
      cfg_en = 1'($urandom); cfg_op = 3'($urandom); cfg_addr = 7'($urandom % 72); cfg_wdata = rnd_row();
      tick();
    end
    cfg_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule